// File: doc/BRIEF.md
# Parallel Panel Write Sequencer

This block sends one frame of pixel words to a display panel that keeps its own frame memory, using an 8080-style parallel write bus: an active-low chip select, an active-low write strobe, a data/command select and a 24-bit data bus. Pixel words arrive on a ready/valid stream. Each word is put on the bus with one write cycle. That cycle is made of four phases whose lengths come from one configuration word: chip-select lead-in, strobe lead-in, strobe low time and hold.

Software writes the configuration word, including its interface-enable bit. It then writes a trigger word with both its mode bit and its command bit set. The block transfers width × height words and then sets a sticky frame-done interrupt, which stays set until it is cleared by writing 1. A non-zero repeat register makes the block start the next frame by itself as soon as one ends. Writing 0 to that register stops the repeats once the current frame finishes.

Top module: `lcd_wseq`

## Requirements
- R1: After reset, chip select and write strobe are high, the pixel stream is not ready, busy and the interrupt are low, and the interface is disabled, so a trigger has no effect until a configuration write sets bit 0.
- R2: A frame starts only on a trigger write with both bit 0 (mode) and bit 1 (command) set while the interface is enabled. A trigger write with only one of those bits set starts nothing.
- R3: In each write cycle, chip select is low with the strobe high for CSS+WRS clocks before the strobe falls. CSS is configuration bits [19:16] and WRS is bits [15:12]. A zero count skips that phase.
- R4: The write strobe is low for ACT clocks (configuration bits [11:8]), and for one clock when ACT is 0. The strobe is only ever low while chip select is low.
- R5: After the strobe rises, chip select stays low for HLD clocks (configuration bits [7:4]). It then goes high for at least one clock before the next word.
- R6: The data/command select is high for the whole time chip select is low. The data bus holds the accepted pixel word, unchanged, from the start to the end of chip select.
- R7: A frame writes exactly width × height words in stream order and writes no word before the stream offers it. Chip select stays high when no frame is running.
- R8: The end of a frame sets the interrupt output, which stays set until an irq_clr pulse clears it.
- R9: A trigger that arrives during a running frame is ignored, so the frame still has exactly width × height words and no second frame follows.
- R10: While the repeat register is non-zero, each frame is followed at once by another one. Writing 0 lets the current frame finish and then stops.
- R11: A trigger with width or height of 0 sets the interrupt without any write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 20 | Phase counts [19:4], interface enable bit 0 |
| trig_we | input | 1 | Trigger word write strobe |
| trig_wdata | input | 2 | Bit 0 mode, bit 1 command |
| afr_we | input | 1 | Repeat register write strobe |
| afr_wdata | input | 8 | Repeat value, 0 disables repeats |
| irq_clr | input | 1 | Write-1 clear of the frame-done interrupt |
| frame_width | input | 10 | Words per line |
| frame_height | input | 10 | Lines per frame |
| pix_valid | input | 1 | Pixel word offered |
| pix_data | input | 24 | Pixel word |
| pix_ready | output | 1 | Pixel word accepted when high with pix_valid |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_rs | output | 1 | Data/command select, high for pixel data |
| lcd_data | output | 24 | Panel data bus |
| busy | output | 1 | Frame transfer in progress |
| irq_done | output | 1 | Sticky frame-done interrupt |

## Verification
On every cycle the assertions check several bus rules. The strobe is low only inside chip select, and the data bus stays still while chip select is low. Each chip-select period begins right after a word is accepted, and the bus stays idle outside a frame. The interrupt stays set until it is cleared. The bench scenarios are the only check on the programmed phase lengths, the word count and order under stream stalls, and the trigger gating and the ignoring of a second trigger. They also cover the repeat mode and the empty frame, since each of these needs a count over a whole frame or a comparison with the settings.

// File: rtl/lcd_wseq_pkg.sv
package lcd_wseq_pkg;

  localparam int PH_W    = 4;
  localparam int CFG_W   = 20;
  localparam int CSS_LSB = 16;
  localparam int WRS_LSB = 12;
  localparam int ACT_LSB = 8;
  localparam int HLD_LSB = 4;
  localparam int EN_BIT  = 0;
  localparam int TRIG_MODE_BIT = 0;
  localparam int TRIG_CMD_BIT  = 1;

  typedef struct packed {
    logic [PH_W-1:0] css;
    logic [PH_W-1:0] wrs;
    logic [PH_W-1:0] act;
    logic [PH_W-1:0] hld;
  } wtime_t;

  localparam wtime_t TIMING_RST = '{css: 4'd0, wrs: 4'd0, act: 4'd1, hld: 4'd0};

  typedef enum logic [2:0] {
    PH_FETCH = 3'd0,
    PH_CSS   = 3'd1,
    PH_WRS   = 3'd2,
    PH_ACT   = 3'd3,
    PH_HLD   = 3'd4
  } phase_e;

  function automatic wtime_t cfg_to_timing(input logic [CFG_W-1:0] w);
    wtime_t t;
    t.css = w[CSS_LSB +: PH_W];
    t.wrs = w[WRS_LSB +: PH_W];
    t.act = w[ACT_LSB +: PH_W];
    t.hld = w[HLD_LSB +: PH_W];
    return t;
  endfunction

  // Next phase in the write cycle, skipping phases programmed to zero.
  function automatic phase_e phase_after(input phase_e cur, input wtime_t t);
    phase_e n;
    case (cur)
      PH_FETCH: n = (t.css != '0) ? PH_CSS : ((t.wrs != '0) ? PH_WRS : PH_ACT);
      PH_CSS:   n = (t.wrs != '0) ? PH_WRS : PH_ACT;
      PH_WRS:   n = PH_ACT;
      PH_ACT:   n = (t.hld != '0) ? PH_HLD : PH_FETCH;
      default:  n = PH_FETCH;
    endcase
    return n;
  endfunction

  // Clocks spent in a phase; the strobe-low phase never drops below one.
  function automatic logic [PH_W-1:0] phase_len(input phase_e p, input wtime_t t);
    logic [PH_W-1:0] l;
    case (p)
      PH_CSS:  l = t.css;
      PH_WRS:  l = t.wrs;
      PH_ACT:  l = (t.act == '0) ? PH_W'(1) : t.act;
      PH_HLD:  l = t.hld;
      default: l = PH_W'(1);
    endcase
    return l;
  endfunction

endpackage

// File: rtl/lcd_wseq_regs.sv
module lcd_wseq_regs
  import lcd_wseq_pkg::*;
#(
  parameter int AFR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               trig_we,
  input  logic [1:0]         trig_wdata,
  input  logic               afr_we,
  input  logic [AFR_W-1:0]   afr_wdata,
  input  logic               irq_clr,
  input  logic               frame_done,
  output wtime_t             timing,
  output logic               start_req,
  output logic               auto_en,
  output logic               irq_done
);

  wtime_t            timing_q, timing_d;
  logic              en_q, en_d;
  logic [AFR_W-1:0]  afr_q, afr_d;
  logic              irq_q, irq_d;

  always_comb begin
    timing_d = timing_q;
    en_d     = en_q;
    if (cfg_we) begin
      timing_d = cfg_to_timing(cfg_wdata);
      en_d     = cfg_wdata[EN_BIT];
    end
    afr_d = afr_q;
    if (afr_we) afr_d = afr_wdata;
    irq_d = irq_q;
    if (irq_clr)    irq_d = 1'b0;
    if (frame_done) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= TIMING_RST;
      en_q     <= 1'b0;
      afr_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      timing_q <= timing_d;
      en_q     <= en_d;
      afr_q    <= afr_d;
      irq_q    <= irq_d;
    end
  end

  assign start_req = trig_we && trig_wdata[TRIG_MODE_BIT] && trig_wdata[TRIG_CMD_BIT] && en_q;
  assign timing    = timing_q;
  assign auto_en   = |afr_q;
  assign irq_done  = irq_q;

endmodule

// File: rtl/lcd_wseq_frame.sv
module lcd_wseq_frame #(
  parameter int W_W = 10,
  parameter int H_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_req,
  input  logic           auto_en,
  input  logic           word_done,
  input  logic [W_W-1:0] frame_width,
  input  logic [H_W-1:0] frame_height,
  output logic           busy,
  output logic           frame_done
);

  localparam int CNT_W = W_W + H_W;

  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  assign total = CNT_W'(frame_width) * CNT_W'(frame_height);

  always_comb begin
    busy_d   = busy_q;
    remain_d = remain_q;
    done_d   = 1'b0;
    if (!busy_q) begin
      if (start_req) begin
        if (total == '0) begin
          done_d = 1'b1;
        end else begin
          busy_d   = 1'b1;
          remain_d = total;
        end
      end
    end else if (word_done) begin
      if (remain_q == CNT_W'(1)) begin
        done_d = 1'b1;
        if (auto_en && (total != '0)) remain_d = total;
        else                          busy_d   = 1'b0;
      end else begin
        remain_d = remain_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
      done_q   <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      remain_q <= remain_d;
      done_q   <= done_d;
    end
  end

  assign busy       = busy_q;
  assign frame_done = done_q;

endmodule

// File: rtl/lcd_wseq_phase.sv
module lcd_wseq_phase
  import lcd_wseq_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  wtime_t            timing,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_ready,
  output logic              cs_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] data,
  output logic              word_done
);

  phase_e            ph_q, ph_d;
  logic [PH_W-1:0]   cnt_q, cnt_d;
  wtime_t            t_q, t_d;
  logic [DATA_W-1:0] data_q, data_d;

  assign pix_ready = run && (ph_q == PH_FETCH);

  always_comb begin
    ph_d      = ph_q;
    cnt_d     = cnt_q;
    t_d       = t_q;
    data_d    = data_q;
    word_done = 1'b0;
    if (ph_q == PH_FETCH) begin
      if (pix_ready && pix_valid) begin
        t_d    = timing;
        data_d = pix_data;
        ph_d   = phase_after(PH_FETCH, timing);
        cnt_d  = phase_len(ph_d, timing) - PH_W'(1);
      end
    end else if (cnt_q == '0) begin
      ph_d = phase_after(ph_q, t_q);
      if (ph_d == PH_FETCH) word_done = 1'b1;
      else                  cnt_d     = phase_len(ph_d, t_q) - PH_W'(1);
    end else begin
      cnt_d = cnt_q - PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_FETCH;
      cnt_q  <= '0;
      t_q    <= TIMING_RST;
      data_q <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      t_q    <= t_d;
      data_q <= data_d;
    end
  end

  assign cs_n = (ph_q == PH_FETCH);
  assign wr_n = (ph_q != PH_ACT);
  assign data = data_q;

endmodule

// File: rtl/lcd_wseq.sv
module lcd_wseq
  import lcd_wseq_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int W_W    = 10,
  parameter int H_W    = 10,
  parameter int AFR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              trig_we,
  input  logic [1:0]        trig_wdata,
  input  logic              afr_we,
  input  logic [AFR_W-1:0]  afr_wdata,
  input  logic              irq_clr,
  input  logic [W_W-1:0]    frame_width,
  input  logic [H_W-1:0]    frame_height,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_ready,
  output logic              lcd_cs_n,
  output logic              lcd_wr_n,
  output logic              lcd_rs,
  output logic [DATA_W-1:0] lcd_data,
  output logic              busy,
  output logic              irq_done
);

  logic [1:0] rst_sync_q;
  logic       rst_n_sync;
  wtime_t     timing;
  logic       start_req, auto_en, frame_done, word_done;
  logic       unused_cfg_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  assign unused_cfg_bits = ^cfg_wdata[HLD_LSB-1:EN_BIT+1];

  lcd_wseq_regs #(.AFR_W(AFR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .trig_we    (trig_we),
    .trig_wdata (trig_wdata),
    .afr_we     (afr_we),
    .afr_wdata  (afr_wdata),
    .irq_clr    (irq_clr),
    .frame_done (frame_done),
    .timing     (timing),
    .start_req  (start_req),
    .auto_en    (auto_en),
    .irq_done   (irq_done)
  );

  lcd_wseq_frame #(.W_W(W_W), .H_W(H_W)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .start_req    (start_req),
    .auto_en      (auto_en),
    .word_done    (word_done),
    .frame_width  (frame_width),
    .frame_height (frame_height),
    .busy         (busy),
    .frame_done   (frame_done)
  );

  lcd_wseq_phase #(.DATA_W(DATA_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .run       (busy),
    .timing    (timing),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_ready (pix_ready),
    .cs_n      (lcd_cs_n),
    .wr_n      (lcd_wr_n),
    .data      (lcd_data),
    .word_done (word_done)
  );

  // Every bus write carries pixel data.
  assign lcd_rs = 1'b1;

endmodule

// File: rtl/lcd_wseq_chk.sv
module lcd_wseq_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_ready,
  input logic              cs_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] data,
  input logic              busy,
  input logic              irq_done,
  input logic              irq_clr
);

  assert_wr_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> $stable(data));

  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> cs_n);

  assert_cs_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(pix_ready));

  assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done && !irq_clr) |=> irq_done);

endmodule

bind lcd_wseq lcd_wseq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .pix_ready (pix_ready),
  .cs_n      (lcd_cs_n),
  .wr_n      (lcd_wr_n),
  .data      (lcd_data),
  .busy      (busy),
  .irq_done  (irq_done),
  .irq_clr   (irq_clr)
);

// File: tb/lcd_wseq_test.sv
`timescale 1ns/1ps
module lcd_wseq_test;

  localparam logic [23:0] PIX_BASE = 24'hA50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [19:0] cfg_wdata = '0;
  logic        trig_we = 1'b0;
  logic [1:0]  trig_wdata = '0;
  logic        afr_we = 1'b0;
  logic [7:0]  afr_wdata = '0;
  logic        irq_clr = 1'b0;
  logic [9:0]  frame_width = '0;
  logic [9:0]  frame_height = '0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic        pix_ready, lcd_cs_n, lcd_wr_n, lcd_rs, busy, irq_done;
  logic [23:0] lcd_data;

  int tests = 0;
  int fails = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  lcd_wseq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .afr_we(afr_we), .afr_wdata(afr_wdata),
    .irq_clr(irq_clr), .frame_width(frame_width), .frame_height(frame_height),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_rs(lcd_rs), .lcd_data(lcd_data),
    .busy(busy), .irq_done(irq_done)
  );

  // Pixel source: words are PIX_BASE + running index.
  int src_idx = 0;
  bit src_gap = 0;
  bit gap_ph = 0;
  always @(posedge clk) if (pix_valid && pix_ready) src_idx <= src_idx + 1;
  always @(negedge clk) begin
    gap_ph    = ~gap_ph;
    pix_valid = !(src_gap && gap_ph);
    pix_data  = PIX_BASE + src_idx[23:0];
  end

  // Bus monitor: one record per chip-select period.
  int nwords = 0;
  int rs_bad = 0;
  int data_bad = 0;
  int pre = 0, act = 0, post = 0;
  bit seen_act = 0;
  logic prev_cs = 1'b1;
  logic [23:0] wd = '0;
  int rec_pre[64];
  int rec_act[64];
  int rec_post[64];
  logic [23:0] rec_dat[64];

  always @(negedge clk) begin
    if (!lcd_cs_n) begin
      if (!lcd_rs) rs_bad++;
      if (!prev_cs && lcd_data != wd) data_bad++;
      wd = lcd_data;
      if (!lcd_wr_n) begin act++; seen_act = 1; end
      else if (seen_act) post++;
      else pre++;
    end else if (!prev_cs) begin
      rec_pre[nwords % 64]  = pre;
      rec_act[nwords % 64]  = act;
      rec_post[nwords % 64] = post;
      rec_dat[nwords % 64]  = wd;
      nwords++;
      pre = 0; act = 0; post = 0; seen_act = 0;
    end
    prev_cs = lcd_cs_n;
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic finish_all();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic wr_cfg(input int c, input int w, input int a, input int h, input bit en);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {c[3:0], w[3:0], a[3:0], h[3:0], 3'b000, en};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic trig(input logic [1:0] v);
    @(negedge clk);
    trig_we = 1'b1;
    trig_wdata = v;
    @(negedge clk);
    trig_we = 1'b0;
  endtask

  task automatic wr_afr(input logic [7:0] v);
    @(negedge clk);
    afr_we = 1'b1;
    afr_wdata = v;
    @(negedge clk);
    afr_we = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic wait_irq(input int limit, output bit ok);
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq_done) begin ok = 1; break; end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "cs_n in reset", int'(lcd_cs_n), 1);
    chk("R1", "wr_n in reset", int'(lcd_wr_n), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "pix_ready after reset", int'(pix_ready), 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "irq after reset", int'(irq_done), 0);
  endtask

  task automatic t_gating();
    int base;
    bit ok;
    frame_width = 10'd2; frame_height = 10'd1;
    base = nwords;
    trig(2'b11);
    repeat (12) @(negedge clk);
    chk("R1", "words with interface disabled", nwords - base, 0);
    chk("R1", "busy with interface disabled", int'(busy), 0);
    wr_cfg(0, 0, 1, 0, 1'b1);
    trig(2'b10);
    repeat (8) @(negedge clk);
    chk("R2", "busy after command-only trigger", int'(busy), 0);
    trig(2'b01);
    repeat (8) @(negedge clk);
    chk("R2", "busy after mode-only trigger", int'(busy), 0);
    chk("R2", "words after partial triggers", nwords - base, 0);
    trig(2'b11);
    chk("R2", "busy after full trigger", int'(busy), 1);
    wait_irq(200, ok);
    chk("R8", "irq after frame", int'(ok), 1);
    repeat (2) @(negedge clk);
    chk("R7", "words in enabled frame", nwords - base, 2);
    clear_irq();
  endtask

  task automatic t_frame(input string name, input int c, input int w, input int a, input int h,
                         input int wd_n, input int ht_n, input bit gap);
    int base, sbase, rb, db, n, exp_act;
    bit ok;
    exp_act = (a == 0) ? 1 : a;
    n = wd_n * ht_n;
    @(negedge clk);
    src_gap = gap;
    frame_width = wd_n[9:0];
    frame_height = ht_n[9:0];
    wr_cfg(c, w, a, h, 1'b1);
    base = nwords; sbase = src_idx; rb = rs_bad; db = data_bad;
    trig(2'b11);
    wait_irq(2000, ok);
    chk("R8", {name, " irq"}, int'(ok), 1);
    repeat (2) @(negedge clk);
    chk("R7", {name, " word count"}, nwords - base, n);
    chk("R7", {name, " busy at end"}, int'(busy), 0);
    for (int i = 0; i < n; i++) begin
      chk("R3", {name, " lead-in clocks"}, rec_pre[(base + i) % 64], c + w);
      chk("R4", {name, " strobe-low clocks"}, rec_act[(base + i) % 64], exp_act);
      chk("R5", {name, " hold clocks"}, rec_post[(base + i) % 64], h);
      chk("R7", {name, " word order"}, int'(rec_dat[(base + i) % 64]), int'(PIX_BASE + 24'(sbase + i)));
    end
    chk("R6", {name, " rs low during write"}, rs_bad - rb, 0);
    chk("R6", {name, " data moved during write"}, data_bad - db, 0);
    clear_irq();
    chk("R8", {name, " irq cleared"}, int'(irq_done), 0);
    src_gap = 0;
  endtask

  task automatic t_busy_trigger();
    int base;
    bit ok;
    frame_width = 10'd2; frame_height = 10'd2;
    wr_cfg(2, 2, 3, 2, 1'b1);
    base = nwords;
    trig(2'b11);
    repeat (10) @(negedge clk);
    trig(2'b11);
    wait_irq(500, ok);
    chk("R9", "irq with extra trigger", int'(ok), 1);
    repeat (40) @(negedge clk);
    chk("R9", "words with extra trigger", nwords - base, 4);
    chk("R9", "busy after frame", int'(busy), 0);
  endtask

  task automatic t_irq_hold();
    repeat (10) @(negedge clk);
    chk("R8", "irq held without clear", int'(irq_done), 1);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R8", "irq after clear pulse", int'(irq_done), 0);
  endtask

  task automatic t_auto();
    int base;
    bit ok;
    frame_width = 10'd2; frame_height = 10'd1;
    wr_cfg(0, 0, 1, 0, 1'b1);
    wr_afr(8'd1);
    base = nwords;
    trig(2'b11);
    wait_irq(200, ok);
    chk("R10", "first repeat frame irq", int'(ok), 1);
    clear_irq();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (nwords - base >= 5) break;
    end
    chk("R10", "still busy in repeat mode", int'(busy), 1);
    chk("R10", "repeats continued", int'(nwords - base >= 5), 1);
    wr_afr(8'd0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (4) @(negedge clk);
    chk("R10", "stopped after repeat off", int'(busy), 0);
    chk("R10", "whole frames only", (nwords - base) % 2, 0);
    chk("R10", "irq at last frame", int'(irq_done), 1);
    clear_irq();
  endtask

  task automatic t_zero();
    int base;
    frame_width = 10'd0; frame_height = 10'd3;
    base = nwords;
    trig(2'b11);
    repeat (6) @(negedge clk);
    chk("R11", "empty frame irq", int'(irq_done), 1);
    chk("R11", "empty frame words", nwords - base, 0);
    chk("R11", "empty frame busy", int'(busy), 0);
    clear_irq();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R7 watchdog: cycles=%0d expected < %0d", 150000, 150000);
    finish_all();
  end

  initial begin
    t_reset();
    t_gating();
    t_frame("default", 0, 0, 1, 0, 3, 1, 1'b0);
    t_frame("zero-act", 0, 0, 0, 0, 2, 2, 1'b0);
    t_frame("long", 3, 2, 4, 1, 2, 3, 1'b0);
    t_frame("stalled", 1, 0, 2, 1, 3, 2, 1'b1);
    t_frame("max", 15, 15, 15, 15, 1, 2, 1'b0);
    t_busy_trigger();
    t_irq_hold();
    t_auto();
    t_zero();
    repeat (5) @(negedge clk);
    finish_all();
  end

endmodule